// File: doc/BRIEF.md
# Screen Buffer Capture by Bus Snooping

This block rebuilds the text screen of a small home computer by listening to its expansion bus. On that machine the CPU "executes" the display file: every character of a text row is fetched as an opcode from the upper half of the address space, and each row ends with the HALT opcode. The block never drives the bus. It synchronises the sampled upper address bit, the active-low opcode-fetch strobe and the eight data lines, spots the quiet gap between frames, locks onto the first terminator after that gap and then follows the fetch stream row by row. Each character code is written, with its row and column, into the write port of an external 24 x 32 dual-port buffer.

Every character row is fetched once per pixel scanline, eight times in all. Only the first pass is written. The later passes are compared with it, and a disagreement sets a sticky error flag. A row cut short by an early terminator is padded with the space code up to the last column. A one-cycle pulse marks the end of the final row, and the block then waits for the next quiet gap.

Top module: `dfile_snoop`

## Requirements
- R1: Each fetch is taken once. A fetch is the upper address bit high while the fetch strobe is low. It is taken on the first synchronised clock with the strobe low and is ignored until the strobe returns high, however long it stays low. Its write appears on the write port 3 clocks after the bus inputs change.
- R2: An opcode fetch seen while the upper address bit is low produces no write and does not move the column.
- R3: The block recognises the gap between frames only after the upper address bit has stayed low for BLANK_CLKS consecutive clocks. After a shorter low spell it ignores every fetch, including terminators.
- R4: Once the gap has been recognised, fetches of codes other than the terminator 0x76 are ignored. The first 0x76 starts the frame at row 0, column 0.
- R5: On the first pass of a row, each non-terminator code is written unchanged at the current row and column. Bit 7 is the inverse flag and bits 0-5 are the glyph index. The column then advances by one.
- R6: A row is fetched PASSES (8) times. The row index advances only after the eighth terminator, and only the first pass writes.
- R7: If the terminator arrives on the first pass before column 31 has been written, the block writes code 0x00 into each remaining column on consecutive clocks, finishing at column 31.
- R8: Characters beyond column 31 in a row are neither written nor compared.
- R9: On passes 2 to 8, a code that differs from the first-pass code in the same column sets the error output, and it stays set until reset.
- R10: The frame-done output pulses for exactly one clock after the last terminator of row 23. The block then ignores fetches until a new gap and a new leading terminator.
- R11: While reset is low, and in the cycle after it, the write enable and the frame-done output are low. The error output is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_a15 | input | 1 | Sampled upper address bit, asynchronous |
| bus_m1_n | input | 1 | Sampled opcode-fetch strobe, active low, asynchronous |
| bus_d | input | 8 | Sampled data bus, asynchronous |
| wr_en | output | 1 | Buffer write enable |
| wr_row | output | 5 | Buffer row 0-23 |
| wr_col | output | 5 | Buffer column 0-31 |
| wr_code | output | 8 | Character code to store |
| frame_done | output | 1 | One-clock pulse at frame end |
| mismatch_err | output | 1 | Sticky flag for a repeat-pass mismatch |

## Verification
The bus inputs pass through two synchroniser flops, and the write port is registered, so a captured code reaches the write port on the third rising edge after the bus changes. Padding writes follow the terminator on consecutive clocks. The bench measures the 3-clock latency directly for one fetch. For all other writes it samples the write port on every falling edge and records each write in a model of the screen. It compares that model with the expected screen only after the frame pulse, plus a few spare clocks. The error flag and the pulse count are checked in that same settled window, and the "nothing written" cases are checked after an idle stretch that is longer than the latency.

// File: rtl/dfs_pkg.sv
// Shared types and constants for the screen snoop.
// Assumes the terminator value is the CPU's HALT opcode.
package dfs_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,   // waiting for the quiet gap
        ST_ARM,    // gap seen, waiting for the leading terminator
        ST_LINE,   // following character fetches
        ST_FILL    // padding a short row with spaces
    } dfs_state_t;

    localparam logic [7:0] TERM_CODE  = 8'h76;
    localparam logic [7:0] SPACE_CODE = 8'h00;
endpackage

// File: rtl/dfs_sync.sv
// Two-flop synchroniser for a bundle of asynchronous inputs.
// Assumes the bundle is sampled slowly enough that skew between bits
// settles within one clock (the bus holds values for several clocks).
module dfs_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    // Two register stages; reset to the bus idle value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/dfs_fetch.sv
// Turns the synchronised strobe into one pulse per upper-half fetch.
// Assumes the strobe goes high between fetches for at least one clock.
module dfs_fetch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_a15,
    input  logic       s_m1_n,
    input  logic [7:0] s_d,
    output logic       fetch_vld,
    output logic [7:0] fetch_code
);
    logic armed_q;

    // Re-arm when the strobe is high, disarm after the first low sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (s_m1_n) armed_q <= 1'b1;
        else             armed_q <= 1'b0;
    end

    assign fetch_vld  = armed_q && !s_m1_n && s_a15;
    assign fetch_code = s_d;
endmodule

// File: rtl/dfs_blank.sv
// Detects the inter-frame gap: the upper address bit low for BLANK_CLKS
// consecutive clocks. The count saturates while the bit stays low.
module dfs_blank #(
    parameter int BLANK_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_a15,
    output logic blank_seen
);
    localparam int CW = $clog2(BLANK_CLKS + 1);
    localparam logic [CW-1:0] LIM = CW'(BLANK_CLKS);

    logic [CW-1:0] cnt_q;

    // Count consecutive low clocks, clear on any high.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (s_a15)        cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign blank_seen = (cnt_q == LIM);
endmodule

// File: rtl/dfs_ctrl.sv
// Frame tracker: follows fetches, writes first-pass codes, pads short
// rows, compares repeat passes and flags the end of a frame.
// Assumes PASSES >= 2. Assumes the bus leaves at least COLS clocks after
// a terminator before the next fetch (the CPU halts for a whole line).
module dfs_ctrl #(
    parameter int ROWS   = 24,
    parameter int COLS   = 32,
    parameter int PASSES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      blank_seen,
    input  logic                      fetch_vld,
    input  logic [7:0]                fetch_code,
    output logic                      wr_en,
    output logic [$clog2(ROWS)-1:0]   wr_row,
    output logic [$clog2(COLS)-1:0]   wr_col,
    output logic [7:0]                wr_code,
    output logic                      frame_done,
    output logic                      mismatch_err
);
    import dfs_pkg::*;

    localparam int ROW_W = $clog2(ROWS);
    localparam int CI_W  = $clog2(COLS);
    localparam int COL_W = $clog2(COLS + 1);
    localparam int PAS_W = $clog2(PASSES);
    localparam logic [COL_W-1:0] COL_END   = COL_W'(COLS);
    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ROWS - 1);
    localparam logic [PAS_W-1:0] PASS_LAST = PAS_W'(PASSES - 1);

    dfs_state_t       state_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [PAS_W-1:0] pass_q;
    logic [7:0]       line_q [COLS];

    logic is_term, in_row, first_pass;
    assign is_term    = (fetch_code == TERM_CODE);
    assign in_row     = (col_q < COL_END);
    assign first_pass = (pass_q == '0);

    // Main sequencer; counters, write port and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_HUNT;
            col_q        <= '0;
            row_q        <= '0;
            pass_q       <= '0;
            wr_en        <= 1'b0;
            wr_row       <= '0;
            wr_col       <= '0;
            wr_code      <= '0;
            frame_done   <= 1'b0;
            mismatch_err <= 1'b0;
        end else begin
            wr_en      <= 1'b0;
            frame_done <= 1'b0;
            case (state_q)
                ST_HUNT: if (blank_seen) state_q <= ST_ARM;
                ST_ARM: begin
                    if (fetch_vld && is_term) begin
                        state_q <= ST_LINE;
                        col_q   <= '0;
                        row_q   <= '0;
                        pass_q  <= '0;
                    end
                end
                ST_LINE: begin
                    if (fetch_vld && is_term) begin
                        if (first_pass && in_row) begin
                            state_q <= ST_FILL;
                        end else begin
                            col_q <= '0;
                            if (pass_q == PASS_LAST) begin
                                pass_q <= '0;
                                if (row_q == ROW_LAST) begin
                                    frame_done <= 1'b1;
                                    state_q    <= ST_HUNT;
                                end else begin
                                    row_q <= row_q + 1'b1;
                                end
                            end else begin
                                pass_q <= pass_q + 1'b1;
                            end
                        end
                    end else if (fetch_vld && in_row) begin
                        if (first_pass) begin
                            wr_en   <= 1'b1;
                            wr_row  <= row_q;
                            wr_col  <= col_q[CI_W-1:0];
                            wr_code <= fetch_code;
                        end else if (line_q[col_q[CI_W-1:0]] != fetch_code) begin
                            mismatch_err <= 1'b1;
                        end
                        col_q <= col_q + 1'b1;
                    end
                end
                ST_FILL: begin
                    wr_en   <= 1'b1;
                    wr_row  <= row_q;
                    wr_col  <= col_q[CI_W-1:0];
                    wr_code <= SPACE_CODE;
                    if (col_q == COL_LAST) begin
                        col_q   <= '0;
                        pass_q  <= PAS_W'(1);
                        state_q <= ST_LINE;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // First-pass copy of the row, used to compare the repeat passes.
    always_ff @(posedge clk) begin
        if (state_q == ST_FILL)
            line_q[col_q[CI_W-1:0]] <= SPACE_CODE;
        else if (state_q == ST_LINE && fetch_vld && !is_term && in_row && first_pass)
            line_q[col_q[CI_W-1:0]] <= fetch_code;
    end
endmodule

// File: rtl/dfile_snoop.sv
// Top level: synchronises the bus, derives fetch pulses and the gap
// indication, and tracks the frame into the buffer write port.
// Assumes the bus is only observed, never driven.
module dfile_snoop #(
    parameter int ROWS       = 24,
    parameter int COLS       = 32,
    parameter int PASSES     = 8,
    parameter int BLANK_CLKS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_a15,
    input  logic                    bus_m1_n,
    input  logic [7:0]              bus_d,
    output logic                    wr_en,
    output logic [$clog2(ROWS)-1:0] wr_row,
    output logic [$clog2(COLS)-1:0] wr_col,
    output logic [7:0]              wr_code,
    output logic                    frame_done,
    output logic                    mismatch_err
);
    logic [9:0] s_bus;
    logic       fetch_vld, blank_seen;
    logic [7:0] fetch_code;

    dfs_sync #(.W(10), .RST_VAL(10'b01_0000_0000)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({bus_a15, bus_m1_n, bus_d}),
        .sync_out(s_bus)
    );

    dfs_fetch u_fetch (
        .clk(clk), .rst_n(rst_n),
        .s_a15(s_bus[9]), .s_m1_n(s_bus[8]), .s_d(s_bus[7:0]),
        .fetch_vld(fetch_vld), .fetch_code(fetch_code)
    );

    dfs_blank #(.BLANK_CLKS(BLANK_CLKS)) u_blank (
        .clk(clk), .rst_n(rst_n), .s_a15(s_bus[9]), .blank_seen(blank_seen)
    );

    dfs_ctrl #(.ROWS(ROWS), .COLS(COLS), .PASSES(PASSES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .blank_seen(blank_seen), .fetch_vld(fetch_vld), .fetch_code(fetch_code),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_code(wr_code),
        .frame_done(frame_done), .mismatch_err(mismatch_err)
    );
endmodule

// File: rtl/dfile_snoop_chk.sv
// Property checker for the snoop's write port and flags.
module dfile_snoop_chk #(
    parameter int ROWS = 24,
    parameter int COLS = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [$clog2(ROWS)-1:0] wr_row,
    input logic [$clog2(COLS)-1:0] wr_col,
    input logic [7:0]              wr_code,
    input logic                    frame_done,
    input logic                    mismatch_err
);
    // R5: writes stay inside the screen.
    p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_row) < ROWS) && (int'(wr_col) < COLS));

    // R7: back-to-back writes only occur while padding, one column apart.
    p_fill_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_col == $past(wr_col) + 1'b1) && (wr_code == 8'h00));

    // R9: the error flag never clears without reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_err |=> mismatch_err);

    // R10: the frame pulse lasts a single clock.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11: reset silences the write port and the pulse.
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> !wr_en && !frame_done && !mismatch_err);
endmodule

bind dfile_snoop dfile_snoop_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_code(wr_code), .frame_done(frame_done), .mismatch_err(mismatch_err)
);

// File: tb/dfile_snoop_test.sv
module dfile_snoop_test;
    localparam int ROWS = 24, COLS = 32, PASSES = 8, BLANK = 16;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_a15 = 1'b1, bus_m1_n = 1'b1;
    logic [7:0] bus_d = 8'h00;
    logic       wr_en, frame_done, mismatch_err;
    logic [4:0] wr_row, wr_col;
    logic [7:0] wr_code;

    always #4 clk = ~clk;

    dfile_snoop #(.BLANK_CLKS(BLANK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_a15(bus_a15), .bus_m1_n(bus_m1_n), .bus_d(bus_d),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_code(wr_code),
        .frame_done(frame_done), .mismatch_err(mismatch_err)
    );

    int checks = 0, errors = 0, cyc = 0, nwr = 0, ndone = 0;
    int first_wr = -1, t0 = 0;
    bit meas = 0;
    logic [7:0] got [ROWS][COLS];
    logic [7:0] expv [ROWS][COLS];
    logic [7:0] rowc [36];

    always @(posedge clk) cyc++;

    // Observe the write port away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                got[wr_row][wr_col] = wr_code;
                nwr++;
                if (first_wr < 0) first_wr = cyc;
            end
            if (frame_done) ndone++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int ex);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, ex);
        end
    endtask

    task automatic fetch(input logic [7:0] code, input int hold = 2);
        @(posedge clk); #1;
        bus_a15 = 1'b1; bus_m1_n = 1'b0; bus_d = code;
        if (meas) begin t0 = cyc; first_wr = -1; meas = 0; end
        repeat (hold) @(posedge clk);
        #1 bus_m1_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic low_fetch(input logic [7:0] code);
        @(posedge clk); #1;
        bus_a15 = 1'b0; bus_m1_n = 1'b0; bus_d = code;
        repeat (2) @(posedge clk);
        #1 bus_m1_n = 1'b1; bus_a15 = 1'b1;
        @(posedge clk);
    endtask

    task automatic gap(input int n);
        @(posedge clk); #1 bus_a15 = 1'b0; bus_m1_n = 1'b1;
        repeat (n) @(posedge clk);
        #1 bus_a15 = 1'b1;
    endtask

    function automatic logic [7:0] rand_char();
        logic [7:0] v;
        v = 8'($urandom_range(0, 63));
        if ($urandom_range(0, 1) == 1) v = v | 8'h80;
        return v;
    endfunction

    // kind 0: full rows plus directed cases; kind 1: collapsed rows; kind 2: mismatch
    task automatic run_frame(input int kind);
        int len, lim, wr_before;
        logic [7:0] code;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) got[r][c] = 8'hAA;
        nwr = 0;
        gap(BLANK + 6);
        if (kind == 0) begin fetch(8'h15); fetch(8'h2A); end   // R4: ignored before start
        fetch(8'h76);
        for (int r = 0; r < ROWS; r++) begin
            if (kind == 0) len = COLS;
            else if (r == 3) len = 0;
            else if (r == 5) len = COLS + 3;                      // R8 overflow row
            else len = $urandom_range(0, COLS);
            for (int c = 0; c < len; c++) rowc[c] = rand_char();
            lim = (len < COLS) ? len : COLS;
            for (int c = 0; c < COLS; c++) expv[r][c] = (c < lim) ? rowc[c] : 8'h00;
            for (int p = 0; p < PASSES; p++) begin
                for (int c = 0; c < len; c++) begin
                    code = rowc[c];
                    if (kind == 2 && r == 7 && p == 5 && c == 0) code = code ^ 8'h01;
                    if (kind == 0 && r == 0 && p == 0 && c == 0) meas = 1;
                    if (kind == 0 && r == 2 && p == 0 && c == 1) fetch(code, 7); // R1 long strobe
                    else fetch(code);
                    if (kind == 0 && r == 1 && p == 0 && c == 3) low_fetch(8'h11); // R2
                end
                fetch(8'h76);
                repeat ((p == 0) ? COLS + 4 : 2) @(posedge clk);
            end
            if (kind == 0 && r == 0) chk(first_wr - t0 == 3, "R1 latency", first_wr - t0, 3);
        end
        repeat (6) @(posedge clk);
        for (int r = 0; r < ROWS; r++) begin
            int bad = -1;
            for (int c = 0; c < COLS; c++) if (got[r][c] !== expv[r][c]) bad = c;
            if (bad < 0) chk(1, "R5 R7", 0, 0);
            else chk(0, $sformatf("R5 R7 R8 row %0d col %0d", r, bad), int'(got[r][bad]), int'(expv[r][bad]));
        end
        chk(nwr == ROWS * COLS, "R6 writes only on first pass", nwr, ROWS * COLS);
        wr_before = ndone;
        // R10: no new frame without a new gap
        fetch(8'h76); fetch(8'h05); fetch(8'h06);
        repeat (8) @(posedge clk);
        chk(nwr == ROWS * COLS, "R10 hunting after frame", nwr, ROWS * COLS);
        chk(wr_before == ndone, "R10 no extra pulse", ndone, wr_before);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1;
        chk(!wr_en && !frame_done && !mismatch_err, "R11 reset state",
            int'({wr_en, frame_done, mismatch_err}), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R3: a short gap must not arm the capture
        gap(BLANK - 3);
        fetch(8'h76); fetch(8'h01); fetch(8'h02); fetch(8'h76);
        repeat (10) @(posedge clk);
        chk(nwr == 0, "R3 short gap ignored", nwr, 0);

        run_frame(0);
        chk(ndone == 1, "R10 one pulse per frame", ndone, 1);
        chk(mismatch_err == 1'b0, "R9 clean frame", int'(mismatch_err), 0);
        run_frame(1);
        chk(ndone == 2, "R10 second frame pulse", ndone, 2);
        chk(mismatch_err == 1'b0, "R9 collapsed rows clean", int'(mismatch_err), 0);
        run_frame(2);
        chk(mismatch_err == 1'b1, "R9 mismatch flagged", int'(mismatch_err), 1);
        repeat (50) @(posedge clk);
        chk(mismatch_err == 1'b1, "R9 flag sticky", int'(mismatch_err), 1);
        chk(ndone == 3, "R10 third frame pulse", ndone, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule